// File: doc/BRIEF.md
# Halfword byte-swapping DMA adapter

This block sits between the DMA side of a 16-bit network controller and a byte-addressed memory port. Each transfer request carries an address, a byte length, a direction and a pass-through flag. The adapter forms the memory address by OR-ing the request address with an upper-address value that is sampled when the request is accepted. It then moves the data 16 bits per beat.

In correcting mode (pass-through flag low) it clears bit 0 of both the address and the length. It then exchanges the two bytes of every halfword in both directions. In pass-through mode the bytes, the address and the length are left as they are, and a final odd byte goes out as a one-byte beat.

Writes are gathered into an internal halfword buffer. They are issued to memory in chunks of at most 64 bytes, each chunk starting where the previous one ended. Reads stream straight back from memory. Only one request is handled at a time. A zero effective length finishes without touching memory.

Top module: `hswap_dma_adapter`

## Requirements
- R1: While reset is high and in the cycle after it, busy, done, mem_req, wr_ready and rd_valid are all 0.
- R2: The first memory beat of a transfer uses address (req_addr | upper_addr), with bit 0 cleared in correcting mode. upper_addr is sampled in the cycle the request is accepted.
- R3: With req_noswap=1, the byte at memory address A+i equals byte i of the stream, and the effective length equals req_len. Stream byte 2k is bits [7:0] of halfword k and stream byte 2k+1 is bits [15:8]. Every beat carries two bytes (mem_pair=1) except a final odd byte, which has mem_pair=0 and leaves the following memory byte unchanged.
- R4: With req_noswap=0, address bit 0 and length bit 0 are cleared. Every beat is two bytes at an even address, so the beat count is len/2.
- R5: In correcting mode a write stores bits [15:8] of halfword k at address A+2k and bits [7:0] at A+2k+1.
- R6: In correcting mode a read returns rd_data = {mem[A+2k], mem[A+2k+1]} for beat k. In pass-through mode it returns {mem[A+2k+1], mem[A+2k]}. rd_valid is high for one cycle per beat, in the cycle after the memory beat is acknowledged.
- R7: A write collects at most 32 halfwords (64 bytes) from the write stream before that chunk is written to memory. Beat n of a transfer goes to address A+2n, so each chunk starts where the last ended. A long request collects exactly 32 halfwords per full chunk.
- R8: A request is accepted only when busy is 0. busy is 1 from the cycle after acceptance up to and including the done cycle. A req_valid pulse while busy is ignored.
- R9: done is a one-cycle pulse in the cycle after the final memory beat is acknowledged. busy is 0 in the following cycle.
- R10: A request whose effective length is 0 raises done in the cycle after acceptance and makes no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upper_addr | input | 32 | Upper-address value OR-ed into every request address |
| req_valid | input | 1 | Request strobe, taken when busy is 0 |
| req_write | input | 1 | 1 = write to memory, 0 = read from memory |
| req_noswap | input | 1 | 1 = pass-through, 0 = even-aligned and byte-swapped |
| req_addr | input | 32 | Request byte address |
| req_len | input | 16 | Request length in bytes |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_data | input | 16 | Write-stream halfword from the controller |
| wr_valid | input | 1 | wr_data is valid |
| wr_ready | output | 1 | Adapter takes wr_data this cycle |
| rd_data | output | 16 | Read halfword to the controller |
| rd_valid | output | 1 | rd_data is valid this cycle |
| mem_req | output | 1 | Memory beat request, held until acknowledged |
| mem_we | output | 1 | Beat is a write |
| mem_pair | output | 1 | 1 = two bytes, 0 = one byte in [7:0] |
| mem_addr | output | 32 | Byte address of the beat |
| mem_wdata | output | 16 | Write data, byte at mem_addr in [7:0] |
| mem_rdata | input | 16 | Read data, byte at mem_addr in [7:0] |
| mem_ack | input | 1 | Memory completes the beat this cycle |

## Verification
The assertions assume that the memory side never raises mem_ack without mem_req. They also assume that the memory answers a read beat through mem_rdata in the same cycle as its acknowledge. The bench models memory as a byte array that drives mem_rdata combinationally and gates mem_ack with mem_req. In some runs it inserts alternating wait cycles. The write stream is always valid during a write, so the chunk-size bound is reached whenever the length allows.

// File: rtl/hswap_pkg.sv
package hswap_pkg;

    localparam int BYTE_LANES = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_DRAIN,
        ST_READ,
        ST_DONE
    } hs_state_e;

    typedef struct packed {
        logic write;
        logic swap;
    } hs_mode_t;

    function automatic logic [31:0] even_addr(input logic [31:0] a);
        return {a[31:1], 1'b0};
    endfunction

endpackage

// File: rtl/hswap_lane.sv
module hswap_lane #(
    parameter int LANES = hswap_pkg::BYTE_LANES
) (
    input  logic               swap_en,
    input  logic [8*LANES-1:0] din,
    output logic [8*LANES-1:0] dout
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign dout[8*i +: 8] = swap_en ? din[8*(LANES-1-i) +: 8] : din[8*i +: 8];
    end
endmodule

// File: rtl/hswap_wbuf.sv
module hswap_wbuf #(
    parameter int DEPTH = 32,
    parameter int W     = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/hswap_dma_adapter.sv
module hswap_dma_adapter
    import hswap_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 16,
    parameter int CHUNK_HW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] upper_addr,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_noswap,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    output logic              busy,
    output logic              done,
    input  logic [15:0]       wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [15:0]       rd_data,
    output logic              rd_valid,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_pair,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ack
);
    localparam int CHUNK_BYTES = 2 * CHUNK_HW;
    localparam int IDX_W       = $clog2(CHUNK_HW);
    localparam int CNT_W       = IDX_W + 1;

    hs_state_e          state;
    hs_mode_t           mode;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   rem;
    logic [CNT_W-1:0]   fill_cnt;
    logic [CNT_W-1:0]   drain_cnt;
    logic [15:0]        rd_data_q;
    logic               rd_valid_q;

    // Request decode at acceptance
    logic [ADDR_W-1:0]  full_addr;
    logic [ADDR_W-1:0]  start_addr;
    logic [LEN_W-1:0]   eff_len;

    assign full_addr  = req_addr | upper_addr;
    assign start_addr = req_noswap ? full_addr : ADDR_W'(even_addr(32'(full_addr)));
    assign eff_len    = req_noswap ? req_len : {req_len[LEN_W-1:1], 1'b0};

    // Chunk sizing
    logic [LEN_W-1:0]   chunk_bytes;
    logic [LEN_W-1:0]   chunk_beats;
    logic               fill_last;
    logic               drain_last;
    logic [LEN_W-1:0]   rd_step;

    assign chunk_bytes = (rem > LEN_W'(CHUNK_BYTES)) ? LEN_W'(CHUNK_BYTES) : rem;
    assign chunk_beats = (chunk_bytes + LEN_W'(1)) >> 1;
    assign fill_last   = (LEN_W'(fill_cnt)  == chunk_beats - LEN_W'(1));
    assign drain_last  = (LEN_W'(drain_cnt) == chunk_beats - LEN_W'(1));
    assign rd_step     = (rem > LEN_W'(1)) ? LEN_W'(2) : LEN_W'(1);

    // Write buffer and byte-lane steering
    logic [15:0] buf_rdata;
    logic [15:0] rd_lane;

    hswap_wbuf #(.DEPTH(CHUNK_HW), .W(16)) wbuf_i (
        .clk   (clk),
        .we    (state == ST_FILL && wr_valid),
        .waddr (fill_cnt[IDX_W-1:0]),
        .wdata (wr_data),
        .raddr (drain_cnt[IDX_W-1:0]),
        .rdata (buf_rdata)
    );

    hswap_lane #(.LANES(BYTE_LANES)) wlane_i (
        .swap_en (mode.swap),
        .din     (buf_rdata),
        .dout    (mem_wdata)
    );

    hswap_lane #(.LANES(BYTE_LANES)) rlane_i (
        .swap_en (mode.swap),
        .din     (mem_rdata),
        .dout    (rd_lane)
    );

    // Memory-side outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_pair = 1'b1;
        mem_addr = cur_addr;
        case (state)
            ST_DRAIN: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_pair = !(drain_last && chunk_bytes[0]);
                mem_addr = cur_addr + ADDR_W'({drain_cnt, 1'b0});
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_pair = (rem > LEN_W'(1));
            end
            default: ;
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);
    assign wr_ready = (state == ST_FILL);
    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            mode       <= '0;
            cur_addr   <= '0;
            rem        <= '0;
            fill_cnt   <= '0;
            drain_cnt  <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        mode.write <= req_write;
                        mode.swap  <= !req_noswap;
                        cur_addr   <= start_addr;
                        rem        <= eff_len;
                        fill_cnt   <= '0;
                        drain_cnt  <= '0;
                        if (eff_len == '0)  state <= ST_DONE;
                        else if (req_write) state <= ST_FILL;
                        else                state <= ST_READ;
                    end
                end
                ST_FILL: begin
                    if (wr_valid) begin
                        fill_cnt <= fill_cnt + CNT_W'(1);
                        if (fill_last) begin
                            drain_cnt <= '0;
                            state     <= ST_DRAIN;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (mem_ack) begin
                        drain_cnt <= drain_cnt + CNT_W'(1);
                        if (drain_last) begin
                            cur_addr <= cur_addr + ADDR_W'(chunk_bytes);
                            rem      <= rem - chunk_bytes;
                            fill_cnt <= '0;
                            state    <= (rem == chunk_bytes) ? ST_DONE : ST_FILL;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= rd_lane;
                        cur_addr   <= cur_addr + ADDR_W'(rd_step);
                        rem        <= rem - rd_step;
                        if (rem == rd_step) state <= ST_DONE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hswap_dma_adapter_chk.sv
module hswap_dma_adapter_chk #(
    parameter int ADDR_W   = 32,
    parameter int CHUNK_HW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic              rd_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_pair,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              swap_act
);
    logic [7:0] gathered;

    always_ff @(posedge clk) begin
        if (rst || done || (mem_req && mem_ack && mem_we)) gathered <= '0;
        else if (wr_valid && wr_ready)                    gathered <= gathered + 8'd1;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && !mem_req && !wr_ready && !rd_valid));

    assert_beat_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_even_pairs_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && swap_act) |-> (!mem_addr[0] && mem_pair));

    assert_read_follows_ack_R6: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(mem_req && mem_ack && !mem_we));

    assert_no_overfill_R7: assert property (@(posedge clk) disable iff (rst)
        gathered <= 8'(CHUNK_HW));

    assert_mem_only_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req || wr_ready) |-> busy);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
endmodule

bind hswap_dma_adapter hswap_dma_adapter_chk #(.ADDR_W(ADDR_W), .CHUNK_HW(CHUNK_HW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_pair (mem_pair),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .swap_act (mode.swap)
);

// File: tb/hswap_dma_adapter_tb_top.sv
module hswap_dma_adapter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 1024;
    localparam int WATCHDOG   = 200000;

    typedef struct packed {
        logic        wr;
        logic        ns;
        logic [31:0] addr;
        logic [15:0] len;
        logic [31:0] upper;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 32'h011, 16'd7,   32'h100},
        '{1'b1, 1'b1, 32'h023, 16'd5,   32'h100},
        '{1'b1, 1'b0, 32'h040, 16'd150, 32'h200},
        '{1'b0, 1'b0, 32'h101, 16'd9,   32'h200},
        '{1'b0, 1'b1, 32'h105, 16'd7,   32'h200},
        '{1'b1, 1'b1, 32'h080, 16'd130, 32'h000},
        '{1'b0, 1'b0, 32'h000, 16'd1,   32'h180},
        '{1'b1, 1'b0, 32'h003, 16'd1,   32'h000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] upper_addr = '0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_noswap = 1'b0;
    logic [31:0] req_addr = '0;
    logic [15:0] req_len = '0;
    logic        busy, done, wr_ready, rd_valid;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_data, rd_data;
    logic        mem_req, mem_we, mem_pair, mem_ack;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;

    hswap_dma_adapter dut_i (
        .clk(clk), .rst(rst), .upper_addr(upper_addr),
        .req_valid(req_valid), .req_write(req_write), .req_noswap(req_noswap),
        .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
        .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_req(mem_req), .mem_we(mem_we), .mem_pair(mem_pair),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack)
    );

    int tests = 0;
    int fails = 0;

    function automatic logic [7:0] ini(input logic [9:0] a);
        return 8'(a * 7 + 3);
    endfunction

    function automatic logic [15:0] pat(input logic [15:0] k);
        return k * 16'h1357 + 16'h2468;
    endfunction

    // Memory model
    logic [7:0] mem [MEM_BYTES];
    logic       slow = 1'b0;
    logic       ph;
    logic [9:0] ra0, ra1;
    assign ra0       = mem_addr[9:0];
    assign ra1       = ra0 + 10'd1;
    assign mem_rdata = {mem[ra1], mem[ra0]};
    assign mem_ack   = mem_req && (!slow || ph);

    always_ff @(posedge clk) begin
        if (rst) ph <= 1'b0;
        else     ph <= ~ph;
    end

    // Write stream source
    logic        wk_clr = 1'b0;
    logic [15:0] wk;
    assign wr_data = pat(wk);
    always_ff @(posedge clk) begin
        if (rst || wk_clr)            wk <= '0;
        else if (wr_valid && wr_ready) wk <= wk + 16'd1;
    end

    // Monitor (negedge)
    logic        mon_clr = 1'b0;
    logic [31:0] exp_base = '0;
    int          beats, addr_err, fill, max_fill, rd_n, req_seen;
    logic [31:0] first_addr;
    logic        last_pair;
    logic [15:0] rd_buf [64];

    always @(negedge clk) begin
        if (rst) begin
            for (int a = 0; a < MEM_BYTES; a++) mem[a] = ini(10'(a));
        end
        if (mon_clr || rst) begin
            beats = 0; addr_err = 0; fill = 0; max_fill = 0; rd_n = 0;
            req_seen = 0; first_addr = '0; last_pair = 1'b0;
        end else begin
            if (mem_req) req_seen++;
            if (wr_valid && wr_ready) begin
                fill++;
                if (fill > max_fill) max_fill = fill;
            end
            if (mem_req && mem_ack) begin
                if (beats == 0) first_addr = mem_addr;
                if (mem_addr != exp_base + 32'(2 * beats)) addr_err++;
                last_pair = mem_pair;
                if (mem_we) begin
                    mem[ra0] = mem_wdata[7:0];
                    if (mem_pair) mem[ra1] = mem_wdata[15:8];
                    fill = 0;
                end
                beats++;
            end
            if (rd_valid && rd_n < 64) begin
                rd_buf[rd_n] = rd_data;
                rd_n++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input bit slw, input bit poke);
        logic [31:0] full, base;
        logic [15:0] elen;
        int          nexp, n, errs, mx;
        full = v.addr | v.upper;
        elen = v.ns ? v.len : {v.len[15:1], 1'b0};
        base = v.ns ? full : {full[31:1], 1'b0};
        nexp = (int'(elen) + 1) / 2;
        @(negedge clk);
        mon_clr = 1'b1; wk_clr = 1'b1; slow = slw;
        upper_addr = v.upper; exp_base = base;
        @(negedge clk);
        mon_clr = 1'b0; wk_clr = 1'b0;
        req_valid = 1'b1; req_write = v.wr; req_noswap = v.ns;
        req_addr = v.addr; req_len = v.len; wr_valid = v.wr;
        @(negedge clk);
        req_valid = 1'b0;
        upper_addr = 32'hFFFF_0000;
        check(busy == 1'b1, "R8", "busy after accept", 32'(busy), 1);
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
            if (poke && n == 10) begin
                req_valid = 1'b1; req_write = 1'b0; req_addr = 32'h3F0; req_len = 16'd4;
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;
        if (elen == 0) begin
            check(n == 0, "R10", "done latency", 32'(n), 0);
            check(req_seen == 0, "R10", "memory requests", 32'(req_seen), 0);
        end
        @(negedge clk);
        wr_valid = 1'b0;
        check(!done && !busy, "R9", "done pulse then idle", {busy, done}, 0);
        check(beats == nexp, v.ns ? "R3" : "R4", "beat count", 32'(beats), 32'(nexp));
        if (nexp > 0) begin
            check(first_addr == base, "R2", "first address", first_addr, base);
            check(addr_err == 0, "R7", "sequential beat addresses", 32'(addr_err), 0);
            check(last_pair == !elen[0], "R3", "final beat width", 32'(last_pair), 32'(!elen[0]));
        end
        if (v.wr && nexp > 0) begin
            errs = 0;
            for (int i = 0; i < int'(elen); i++) begin
                logic [15:0] hw;
                logic [7:0]  eb;
                hw = pat(16'(i / 2));
                if (v.ns) eb = (i % 2 == 0) ? hw[7:0] : hw[15:8];
                else      eb = (i % 2 == 0) ? hw[15:8] : hw[7:0];
                if (mem[10'(base + 32'(i))] != eb) errs++;
            end
            check(errs == 0, v.ns ? "R3" : "R5", "written bytes mismatching", 32'(errs), 0);
            mx = (nexp > 32) ? 32 : nexp;
            check(max_fill == mx, "R7", "largest gathered chunk", 32'(max_fill), 32'(mx));
            if (elen[0]) begin
                check(mem[10'(base + 32'(elen))] == ini(10'(base + 32'(elen))), "R3",
                      "byte after odd tail", 32'(mem[10'(base + 32'(elen))]),
                      32'(ini(10'(base + 32'(elen)))));
            end
        end
        if (!v.wr && nexp > 0) begin
            check(rd_n == nexp, "R6", "read beats delivered", 32'(rd_n), 32'(nexp));
            errs = 0;
            for (int k = 0; k < nexp && k < rd_n; k++) begin
                logic [7:0]  lo, hi;
                logic [15:0] ex;
                lo = mem[10'(base + 32'(2 * k))];
                hi = mem[10'(base + 32'(2 * k + 1))];
                ex = v.ns ? {hi, lo} : {lo, hi};
                if (v.ns && elen[0] && k == nexp - 1) begin
                    if (rd_buf[k][7:0] != ex[7:0]) errs++;
                end else if (rd_buf[k] != ex) begin
                    errs++;
                end
            end
            check(errs == 0, "R6", "read halfwords mismatching", 32'(errs), 0);
        end
    endtask

    // Watchdog
    int cycles = 0;
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check({busy, done, mem_req, wr_ready, rd_valid} == 5'b0, "R1", "outputs in reset",
              32'({busy, done, mem_req, wr_ready, rd_valid}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({busy, done, mem_req, wr_ready, rd_valid} == 5'b0, "R1", "outputs after reset",
              32'({busy, done, mem_req, wr_ready, rd_valid}), 0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], i[0], 1'b0);

        // R8: a request strobe during a long write is ignored
        run_vec('{1'b1, 1'b0, 32'h041, 16'd140, 32'h200}, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check(!busy, "R8", "no second transfer started", 32'(busy), 0);
        check(rd_n == 0, "R8", "no read beats from ignored strobe", 32'(rd_n), 0);

        // R10: zero length in pass-through mode
        run_vec('{1'b1, 1'b1, 32'h055, 16'd0, 32'h000}, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule